// File: doc/BRIEF.md
# Interlaced Composite Raster Generator

This block produces the sample-rate sequencing for a digital composite video stream. The stream drives a 10-bit binary-coded DAC clocked at 27 MHz. One input selects either a 525-line standard or a 625-line standard. For the chosen standard the block runs a sample counter and a line counter. It splits every frame into two interlaced fields and marks the horizontal and vertical blanking and sync intervals. For each sample it emits one level code.

During picture samples the block supplies a row and column address to an external frame store. The frame store holds a 480-row image and answers with an 8-bit luminance value in the same cycle. The block scales that value between the black and white codes. When a line position maps to a row beyond the stored image, the block emits the black code and does not fetch. A field-parity output and a start-of-field strobe mark the field sequence for downstream logic.

Top module: `raster_gen`

## Requirements
- R1: While `rst` is high and on the first falling clock edge after it is released, `dacCode` holds the blank code (292 by default). At that point the raster is at line 0, sample 0: `fieldStart` is 1, `fieldOdd` is 1 and `pixActive` is 0.
- R2: In each standard a line has a fixed number of samples. In the 525-line standard this is 1716 by default, of which the first 308 are horizontal blanking. In the 625-line standard it is 1728, of which the first 324 are blanking. Picture samples follow the blanking, and `srcCol` equals the sample index minus the blanking length.
- R3: A frame has 525 or 625 lines. The first field is the first ceil(lines/2) lines, and `fieldOdd` is 1 throughout it. The second field is the remaining lines, and `fieldOdd` is 0 throughout it. `fieldStart` is 1 only on sample 0 of the first line of each field.
- R4: The first 22 lines (525-line standard) or 25 lines (625-line standard) of each field carry only sync and blank codes. `pixActive` stays 0 on those lines.
- R5: The k-th picture line of a field (counting from 0) fetches a fixed row of the stored image. In the first field it is row 2k on `srcRow`, which is source rows 1, 3, 5 and so on, counted from 1. In the second field it is row 2k+1, which is rows 2, 4, 6 and so on.
- R6: The first picture line of the second field starts its picture at mid-line, at sample lineLength/2. Its first half carries sync and blank only. This supplies the half line of vertical blanking.
- R7: A picture line whose `srcRow` is 480 or more outputs the black code (344 by default) on every picture sample, and `pixActive` stays 0 on that line.
- R8: The first 127 samples of every line, including blanking lines, output the sync-tip code (0 by default).
- R9: A fetched picture sample with luminance p outputs black + ((p × (white − black)) >> 8), with white = 1023 by default. All other non-sync samples output the blank code. `dacCode` appears one clock after the raster position it describes.
- R10: `modeIn` = 0 selects the 525-line standard and `modeIn` = 1 selects the 625-line standard. The block samples it during reset and on the last sample of each frame. A change in the middle of a frame has no effect until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst | input | 1 | Synchronous reset, active high |
| modeIn | input | 1 | Line standard select: 0 = 525 lines, 1 = 625 lines |
| pixIn | input | 8 | Luminance from the frame store for the current address |
| dacCode | output | 10 | Registered binary level code for the DAC |
| srcRow | output | 10 | Source image row to fetch, valid while `pixActive` |
| srcCol | output | 11 | Source image column to fetch, valid while `pixActive` |
| pixActive | output | 1 | High when the current sample fetches a stored pixel |
| fieldOdd | output | 1 | High throughout the first field of a frame |
| fieldStart | output | 1 | One-sample strobe at the first sample of each field |

## Verification
The bench compares every sample of complete frames against a model written from the requirements. It runs one whole frame in each standard. A third run switches the standard select in the middle of a frame. The luminance pattern varies with both row and column, so a wrong row order, a column offset, or picture fetched on a blanking line or black-filled line each produce a code mismatch rather than a silent match. The mid-frame switch separates a design that latches the standard only at the frame boundary from one that follows the input at once, because the two differ in line length on the very next line.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Per-sample level selection passed from sequencing to the code path.
  typedef struct packed {
    logic syncTip;    // sample lies in the line's sync pulse
    logic picture;    // sample lies in the picture region of a video line
    logic blackFill;  // picture region maps past the stored image
  } lvlCtl_t;

endpackage

// File: rtl/raster_timing.sv
module raster_timing
  import raster_pkg::*;
#(
  parameter int LINE_N   = 1716,
  parameter int HBLANK_N = 308,
  parameter int LINES_N  = 525,
  parameter int VBLANK_N = 22,
  parameter int LINE_P   = 1728,
  parameter int HBLANK_P = 324,
  parameter int LINES_P  = 625,
  parameter int VBLANK_P = 25,
  parameter int SYNC_W   = 127,
  parameter int SRC_ROWS = 480,
  parameter int HW       = 11,
  parameter int VW       = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          modeIn,
  output lvlCtl_t       ctl,
  output logic [VW-1:0] srcRow,
  output logic [HW-1:0] srcCol,
  output logic          pixActive,
  output logic          fieldOdd,
  output logic          fieldStart,
  output logic          stdSel
);

  localparam logic [HW-1:0] H_LAST_N = HW'(LINE_N - 1);
  localparam logic [HW-1:0] H_LAST_P = HW'(LINE_P - 1);
  localparam logic [HW-1:0] H_HALF_N = HW'(LINE_N / 2);
  localparam logic [HW-1:0] H_HALF_P = HW'(LINE_P / 2);
  localparam logic [HW-1:0] HB_N     = HW'(HBLANK_N);
  localparam logic [HW-1:0] HB_P     = HW'(HBLANK_P);
  localparam logic [VW-1:0] V_LAST_N = VW'(LINES_N - 1);
  localparam logic [VW-1:0] V_LAST_P = VW'(LINES_P - 1);
  localparam logic [VW-1:0] F1_N     = VW'((LINES_N + 1) / 2);
  localparam logic [VW-1:0] F1_P     = VW'((LINES_P + 1) / 2);
  localparam logic [VW-1:0] VB_N     = VW'(VBLANK_N);
  localparam logic [VW-1:0] VB_P     = VW'(VBLANK_P);
  localparam logic [HW-1:0] SYNC_END = HW'(SYNC_W);
  localparam logic [VW-1:0] ROW_LIM  = VW'(SRC_ROWS);

  logic [HW-1:0] hCnt, hLast, hHalf, hbLen, pixStart;
  logic [VW-1:0] vCnt, vLast, f1Len, vbLen;
  logic [VW-1:0] lineInField, activeIdx, rowIdx;
  logic          firstField, vidLine, halfLine, inPix, blackRow;

  // Standard-dependent geometry, fixed for the whole frame by stdSel.
  always_comb begin
    hLast = stdSel ? H_LAST_P : H_LAST_N;
    hHalf = stdSel ? H_HALF_P : H_HALF_N;
    hbLen = stdSel ? HB_P     : HB_N;
    vLast = stdSel ? V_LAST_P : V_LAST_N;
    f1Len = stdSel ? F1_P     : F1_N;
    vbLen = stdSel ? VB_P     : VB_N;
  end

  // Sample and line counters; the standard is taken only at frame wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt   <= '0;
      vCnt   <= '0;
      stdSel <= modeIn;
    end else if (hCnt == hLast) begin
      hCnt <= '0;
      if (vCnt == vLast) begin
        vCnt   <= '0;
        stdSel <= modeIn;
      end else begin
        vCnt <= vCnt + 1'b1;
      end
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    firstField  = vCnt < f1Len;
    lineInField = firstField ? vCnt : vCnt - f1Len;
    vidLine     = lineInField >= vbLen;
    activeIdx   = lineInField - vbLen;
    // first field fetches even indices, second field odd ones
    rowIdx      = {activeIdx[VW-2:0], ~firstField};
    halfLine    = ~firstField & vidLine & (activeIdx == '0);
    pixStart    = halfLine ? hHalf : hbLen;
    inPix       = vidLine & (hCnt >= pixStart);
    blackRow    = rowIdx >= ROW_LIM;

    ctl.syncTip   = hCnt < SYNC_END;
    ctl.picture   = inPix;
    ctl.blackFill = blackRow;

    srcRow     = rowIdx;
    srcCol     = hCnt - hbLen;
    pixActive  = inPix & ~blackRow;
    fieldOdd   = firstField;
    fieldStart = (hCnt == '0) & ((vCnt == '0) | (vCnt == f1Len));
  end

endmodule

// File: rtl/raster_levels.sv
module raster_levels
  import raster_pkg::*;
#(
  parameter int PIXW        = 8,
  parameter int DW          = 10,
  parameter int CODE_SYNC   = 0,
  parameter int CODE_BLANK  = 292,
  parameter int CODE_BLACK  = 344,
  parameter int CODE_WHITE  = 1023
) (
  input  logic            clk,
  input  logic            rst,
  input  lvlCtl_t         ctl,
  input  logic [PIXW-1:0] pixIn,
  output logic [DW-1:0]   dacCode
);

  localparam int            PW    = PIXW + DW;
  localparam logic [PW-1:0] SPAN  = PW'(CODE_WHITE - CODE_BLACK);
  localparam logic [DW-1:0] L_SYNC  = DW'(CODE_SYNC);
  localparam logic [DW-1:0] L_BLANK = DW'(CODE_BLANK);
  localparam logic [DW-1:0] L_BLACK = DW'(CODE_BLACK);

  logic [PW-1:0] scaled;
  logic [DW-1:0] picCode, nextCode;

  always_comb begin
    scaled  = (PW'(pixIn) * SPAN) >> PIXW;
    picCode = L_BLACK + DW'(scaled);
    if (ctl.syncTip)      nextCode = L_SYNC;
    else if (ctl.picture) nextCode = ctl.blackFill ? L_BLACK : picCode;
    else                  nextCode = L_BLANK;
  end

  always_ff @(posedge clk) begin
    if (rst) dacCode <= L_BLANK;
    else     dacCode <= nextCode;
  end

endmodule

// File: rtl/raster_gen.sv
module raster_gen
  import raster_pkg::*;
#(
  parameter int LINE_N     = 1716,
  parameter int HBLANK_N   = 308,
  parameter int LINES_N    = 525,
  parameter int VBLANK_N   = 22,
  parameter int LINE_P     = 1728,
  parameter int HBLANK_P   = 324,
  parameter int LINES_P    = 625,
  parameter int VBLANK_P   = 25,
  parameter int SYNC_W     = 127,
  parameter int SRC_ROWS   = 480,
  parameter int HW         = 11,
  parameter int VW         = 10,
  parameter int PIXW       = 8,
  parameter int DW         = 10,
  parameter int CODE_SYNC  = 0,
  parameter int CODE_BLANK = 292,
  parameter int CODE_BLACK = 344,
  parameter int CODE_WHITE = 1023
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            modeIn,
  input  logic [PIXW-1:0] pixIn,
  output logic [DW-1:0]   dacCode,
  output logic [VW-1:0]   srcRow,
  output logic [HW-1:0]   srcCol,
  output logic            pixActive,
  output logic            fieldOdd,
  output logic            fieldStart
);

  lvlCtl_t ctl;
  logic    stdSel;

  raster_timing #(
    .LINE_N(LINE_N), .HBLANK_N(HBLANK_N), .LINES_N(LINES_N), .VBLANK_N(VBLANK_N),
    .LINE_P(LINE_P), .HBLANK_P(HBLANK_P), .LINES_P(LINES_P), .VBLANK_P(VBLANK_P),
    .SYNC_W(SYNC_W), .SRC_ROWS(SRC_ROWS), .HW(HW), .VW(VW)
  ) timing_i (
    .clk(clk), .rst(rst), .modeIn(modeIn), .ctl(ctl),
    .srcRow(srcRow), .srcCol(srcCol), .pixActive(pixActive),
    .fieldOdd(fieldOdd), .fieldStart(fieldStart), .stdSel(stdSel)
  );

  raster_levels #(
    .PIXW(PIXW), .DW(DW), .CODE_SYNC(CODE_SYNC), .CODE_BLANK(CODE_BLANK),
    .CODE_BLACK(CODE_BLACK), .CODE_WHITE(CODE_WHITE)
  ) levels_i (
    .clk(clk), .rst(rst), .ctl(ctl), .pixIn(pixIn), .dacCode(dacCode)
  );

endmodule

// File: rtl/raster_gen_chk.sv
module raster_gen_chk #(
  parameter int SRC_ROWS   = 480,
  parameter int VW         = 10,
  parameter int DW         = 10,
  parameter int CODE_SYNC  = 0,
  parameter int CODE_BLACK = 344,
  parameter int CODE_WHITE = 1023
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] dacCode,
  input logic [VW-1:0] srcRow,
  input logic          pixActive,
  input logic          fieldOdd,
  input logic          fieldStart,
  input logic          stdSel
);

  // R3: parity only changes where a field begins
  a_r3_parity_at_field_start: assert property (@(posedge clk) disable iff (rst)
    (fieldOdd != $past(fieldOdd)) |-> fieldStart);

  // R10: the standard only changes at the first sample of a frame
  a_r10_std_at_frame_start: assert property (@(posedge clk) disable iff (rst)
    (stdSel != $past(stdSel)) |-> (fieldStart && fieldOdd));

  // R7: never fetch beyond the stored image
  a_r7_no_fetch_past_image: assert property (@(posedge clk) disable iff (rst)
    pixActive |-> (srcRow < VW'(SRC_ROWS)));

  // R8: each field opens with the sync tip one clock later
  a_r8_sync_opens_field: assert property (@(posedge clk) disable iff (rst)
    fieldStart |=> (dacCode == DW'(CODE_SYNC)));

  // R9: fetched samples land between black and white
  a_r9_picture_in_range: assert property (@(posedge clk) disable iff (rst)
    pixActive |=> ((dacCode >= DW'(CODE_BLACK)) && (dacCode <= DW'(CODE_WHITE))));

  // R4: the first line of a field is vertical blanking
  a_r4_no_fetch_at_field_start: assert property (@(posedge clk) disable iff (rst)
    fieldStart |-> !pixActive);

endmodule

bind raster_gen raster_gen_chk #(
  .SRC_ROWS(SRC_ROWS), .VW(VW), .DW(DW),
  .CODE_SYNC(CODE_SYNC), .CODE_BLACK(CODE_BLACK), .CODE_WHITE(CODE_WHITE)
) chk_i (
  .clk(clk), .rst(rst), .dacCode(dacCode), .srcRow(srcRow),
  .pixActive(pixActive), .fieldOdd(fieldOdd), .fieldStart(fieldStart),
  .stdSel(stdSel)
);

// File: tb/raster_gen_tb_top.sv
`timescale 1ns/1ps
module raster_gen_tb_top;

  // Scaled raster so whole frames fit in a short run.
  localparam int L_N = 40, HB_N = 10, F_N = 15, VB_N = 2;
  localparam int L_P = 44, HB_P = 12, F_P = 17, VB_P = 3;
  localparam int SW = 4, SRC = 6;
  localparam int C_SYNC = 0, C_BLANK = 292, C_BLACK = 344, C_WHITE = 1023;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        modeIn = 1'b0;
  logic [7:0]  pixIn;
  logic [9:0]  dacCode;
  logic [9:0]  srcRow;
  logic [10:0] srcCol;
  logic        pixActive, fieldOdd, fieldStart;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  int    mv, mh;
  logic  mMode;
  int    prevCode;
  string prevTag;

  always #2.5 clk = ~clk;

  // Frame store: luminance depends on both row and column.
  assign pixIn = 8'((int'(srcRow) * 37 + int'(srcCol) * 5) % 256);

  raster_gen #(
    .LINE_N(L_N), .HBLANK_N(HB_N), .LINES_N(F_N), .VBLANK_N(VB_N),
    .LINE_P(L_P), .HBLANK_P(HB_P), .LINES_P(F_P), .VBLANK_P(VB_P),
    .SYNC_W(SW), .SRC_ROWS(SRC)
  ) dut_i (
    .clk(clk), .rst(rst), .modeIn(modeIn), .pixIn(pixIn),
    .dacCode(dacCode), .srcRow(srcRow), .srcCol(srcCol),
    .pixActive(pixActive), .fieldOdd(fieldOdd), .fieldStart(fieldStart)
  );

  function automatic int pat(input int r, input int c);
    return (r * 37 + c * 5) % 256;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (line %0d sample %0d)",
               req, what, act, exp, mv, mh);
    end
  endtask

  // Expected outputs at raster position (v,h) from the requirements.
  task automatic predict(input logic md, input int v, input int h,
                         output bit eOdd, output bit eStart, output bit eAct,
                         output int eRow, output int eCol, output int eCode,
                         output string tAct, output string tCode);
    int L, HB, F, VB, F1, lf, k, row, start;
    bit f1, vid, half, inPix, blk;
    L  = md ? L_P : L_N;
    HB = md ? HB_P : HB_N;
    F  = md ? F_P : F_N;
    VB = md ? VB_P : VB_N;
    F1 = (F + 1) / 2;
    f1 = v < F1;
    lf = f1 ? v : v - F1;
    vid = lf >= VB;
    k = lf - VB;
    row = 2 * k + (f1 ? 0 : 1);            // R5 ordering
    half = !f1 && vid && (k == 0);         // R6 mid-line start
    start = half ? L / 2 : HB;
    inPix = vid && (h >= start);
    blk = row >= SRC;                      // R7 black fill
    eOdd = f1;
    eStart = (h == 0) && (v == 0 || v == F1);
    eAct = inPix && !blk;
    eRow = row;
    eCol = h - HB;
    if (h < SW) eCode = C_SYNC;
    else if (inPix) eCode = blk ? C_BLACK : C_BLACK + ((pat(row, eCol) * (C_WHITE - C_BLACK)) >> 8);
    else eCode = C_BLANK;
    if (!vid) tAct = "R4";
    else if (half && h >= HB && h < start) tAct = "R6";
    else if (inPix && blk) tAct = "R7";
    else tAct = "R2";
    if (h < SW) tCode = "R8";
    else if (inPix) tCode = blk ? "R7" : "R9";
    else if (!vid) tCode = "R4";
    else tCode = (half && h >= HB) ? "R6" : "R2";
  endtask

  // Compare one sample, then advance the model and the clock.
  task automatic stepCheck(input string ovr);
    bit eOdd, eStart, eAct;
    int eRow, eCol, eCode, L, F;
    string tAct, tCode, t;
    predict(mMode, mv, mh, eOdd, eStart, eAct, eRow, eCol, eCode, tAct, tCode);
    t = (ovr.len() > 0) ? ovr : "R3";
    chk(t, "fieldOdd", int'(fieldOdd), int'(eOdd));
    chk(t, "fieldStart", int'(fieldStart), int'(eStart));
    chk((ovr.len() > 0) ? ovr : tAct, "pixActive", int'(pixActive), int'(eAct));
    if (eAct) begin
      chk((ovr.len() > 0) ? ovr : "R5", "srcRow", int'(srcRow), eRow);
      chk((ovr.len() > 0) ? ovr : "R2", "srcCol", int'(srcCol), eCol);
    end
    chk((ovr.len() > 0) ? ovr : prevTag, "dacCode", int'(dacCode), prevCode);
    prevCode = eCode;
    prevTag  = tCode;
    L = mMode ? L_P : L_N;
    F = mMode ? F_P : F_N;
    if (mh == L - 1) begin
      mh = 0;
      if (mv == F - 1) begin
        mv = 0;
        mMode = modeIn;
      end else mv++;
    end else mh++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mv = 0; mh = 0; mMode = modeIn;
    prevCode = C_BLANK; prevTag = "R1";
    // R1: reset state
    chk("R1", "dacCode after reset", int'(dacCode), C_BLANK);
    chk("R1", "fieldStart after reset", int'(fieldStart), 1);
    chk("R1", "fieldOdd after reset", int'(fieldOdd), 1);
    chk("R1", "pixActive after reset", int'(pixActive), 0);
  endtask

  task automatic test_std525_frame();
    modeIn = 1'b0;
    applyReset();
    repeat (L_N * F_N + 60) stepCheck("");
  endtask

  task automatic test_std625_frame();
    modeIn = 1'b1;
    applyReset();
    repeat (L_P * F_P + 60) stepCheck("");
  endtask

  // R10: a mid-frame change waits for the frame boundary
  task automatic test_mode_switch();
    modeIn = 1'b0;
    applyReset();
    repeat (250) stepCheck("");
    modeIn = 1'b1;
    repeat (L_N * F_N - 250 + L_P * 6) stepCheck("R10");
    modeIn = 1'b0;
    repeat (L_P * F_P) stepCheck("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout, expected run completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    test_std525_frame();
    test_std625_frame();
    test_mode_switch();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule